// File: doc/BRIEF.md
# Windowed Indirect MMD Register Bridge

This block is a memory-mapped slave that gives a host reach into a wide management register space through a small address window. A register in that space has a 21-bit full address: a 5-bit device number in bits 20:16 and a 16-bit register number in bits 15:0. The host forms the full address in one of two ways. If the clause-45 flag (bit 30 of the request) is set, the full address is the request with that flag cleared. Otherwise it is the current device number shifted left by 16, OR-ed with the low 16 bits of the register number. Every access then takes two bus transfers. The first writes a window-select register with the upper part of the address. The second reads or writes a location inside the window, and that location's offset carries the lower part.

A static input, `layout_mode`, picks one of two layouts over the same register space. In the word layout (value 0), the select register sits at byte offset 0x3FC and takes the full address shifted right by 8. The data location is the low 8 address bits times 4, and the data is a 32-bit word. In the halfword layout (value 1, and also values 2 and 3), the full address is first doubled. The select register sits at byte offset 0x9064 and takes the doubled address with its window-mask bits cleared. The data location is the window base plus the doubled address masked to the window size, and the data is a halfword in bus bits 15:0. A small internal store of 16-bit registers stands in for the register space, so that the bridge can be checked end to end.

Every transfer is acknowledged one cycle after it is presented. Read data arrives together with that acknowledge.

Top module: `mmd_window_bridge`

## Requirements
- R1: After reset, `bus_ack` is 0 and the window-select register reads back as 0 in either layout.
- R2: A transfer presented with `bus_sel`=1 at a clock edge gives `bus_ack`=1 after that edge, together with its read data. `bus_ack` is 0 after every edge at which `bus_sel` was 0.
- R3: In layout 0, a write to byte offset 0x3FC stores all 32 data bits in the select register, and a read of 0x3FC returns them.
- R4: In layout 0, a read or write at a byte offset below 0x400 with bits 1:0 clear reaches full address {select[12:0], offset[9:2]}. A read returns the 16-bit register value zero-extended to 32 bits.
- R5: In layout 0, offset 0x3FC always reaches the select register and never the register store.
- R6: In layout 1, the select register sits at byte offset 0x9064, with a 32-bit write and readback.
- R7: In layout 1, an even byte offset inside [WIN_BASE, WIN_BASE+WIN_SIZE) reaches full address ((select AND NOT (WIN_SIZE-1)) OR (offset-WIN_BASE)) >> 1. The halfword sits in bus bits 15:0, and reads are zero-extended.
- R8: Layout values 2 and 3 behave exactly as layout 1.
- R9: A transfer that hits neither the select register nor the data window of the current layout reads as 0 and changes no state. This covers misaligned offsets and the other layout's select offset.
- R10: A full address with device number >= N_DEV or register number >= N_REG reads as 0, and writes to it change nothing.
- R11: A data write stores only bus bits 15:0. Bits 31:16 of the write data are ignored.
- R12: Both layouts reach one shared register store, so a value written through one layout reads back through the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| layout_mode | input | 2 | Access layout: 0 word, any other value halfword; held static |
| bus_sel | input | 1 | Transfer request, one cycle per transfer |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the transfer |
| bus_wdata | input | 32 | Write data |
| bus_ack | output | 1 | Transfer completed, one cycle after the request |
| bus_rdata | output | 32 | Read data, valid while `bus_ack` is 1 |

## Verification
The only internal state is the select register and the register store, and both appear at the ports one transfer later. A corrupted select value sends the very next data transfer to the wrong register. It also shows directly at the select offset's readback in the cycle after the read. A decode fault in the address rebuild shows up as a value read back from a register other than the one written. The bench keeps its own model of every register and compares each data read against it. It checks the layout-0 and layout-1 address arithmetic on addresses whose device and register fields both differ from zero. It also reads across layouts, so that a fault in one layout's address rebuild cannot cancel itself out on readback.

// File: rtl/mwb_pkg.sv
package mwb_pkg;
   localparam int DEV_W  = 5;
   localparam int REG_W  = 16;
   localparam int FULL_W = DEV_W + REG_W;
   localparam int BUS_W  = 32;
   localparam int HALF_W = 16;

   localparam logic [1:0] MODE_WORD = 2'd0;

   typedef struct packed {
      logic              hit_sel;
      logic              hit_data;
      logic [FULL_W-1:0] full;
   } dec_t;
endpackage

// File: rtl/mwb_layout_dec.sv
module mwb_layout_dec
   import mwb_pkg::*;
#(
   parameter int          ADDR_W   = 16,
   parameter bit          HALF     = 1'b0,
   parameter int unsigned SEL_OFF  = 32'h3FC,
   parameter int unsigned WIN_BASE = 32'h8000,
   parameter int unsigned WIN_SIZE = 4096
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [BUS_W-1:0]  sel_q,
   output dec_t              dec
);
   localparam int WIN_LOG = $clog2(WIN_SIZE);
   localparam logic [ADDR_W-1:0] SEL_V  = ADDR_W'(SEL_OFF);
   localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(WIN_BASE);
   localparam logic [BUS_W-1:0]  MASK_V = BUS_W'(WIN_SIZE - 1);

   if ((WIN_SIZE & (WIN_SIZE - 1)) != 0 || WIN_SIZE < 4) begin : g_bad_size
      $error("WIN_SIZE must be a power of two of at least 4");
   end
   if ((WIN_BASE % WIN_SIZE) != 0) begin : g_bad_base
      $error("WIN_BASE must be aligned to WIN_SIZE");
   end
   if (WIN_LOG >= ADDR_W || ADDR_W < 12) begin : g_bad_addr
      $error("ADDR_W too small for the window or the word layout");
   end

   if (HALF) begin : g_half
      logic             in_win;
      logic [BUS_W-1:0] win_off;
      logic [BUS_W-1:0] shifted;
      logic [BUS_W-FULL_W-1:0] unused_sh_bits;

      always_comb begin
         win_off = '0;
         win_off[WIN_LOG-1:0] = addr[WIN_LOG-1:0];
      end
      assign in_win   = (addr[ADDR_W-1:WIN_LOG] == BASE_V[ADDR_W-1:WIN_LOG]);
      assign shifted  = (sel_q & ~MASK_V) | win_off;
      assign dec.hit_sel  = (addr == SEL_V);
      assign dec.hit_data = in_win && !addr[0] && !dec.hit_sel;
      assign dec.full     = shifted[FULL_W:1];
      assign unused_sh_bits = {shifted[BUS_W-1:FULL_W+1], shifted[0]};
   end else begin : g_word
      logic [BUS_W-FULL_W+7:0] unused_sel_bits;

      assign dec.hit_sel  = (addr == SEL_V);
      assign dec.hit_data = !dec.hit_sel && (addr[1:0] == 2'b00)
                            && (addr[ADDR_W-1:10] == '0);
      assign dec.full     = {sel_q[FULL_W-9:0], addr[9:2]};
      assign unused_sel_bits = sel_q[BUS_W-1:FULL_W-8];
   end
endmodule

// File: rtl/mwb_select_reg.sv
module mwb_select_reg
   import mwb_pkg::*;
(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [BUS_W-1:0] wdata,
   output logic [BUS_W-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     q <= '0;
      else if (wr_en) q <= wdata;
   end
endmodule

// File: rtl/mwb_mmd_store.sv
module mwb_mmd_store
   import mwb_pkg::*;
#(
   parameter int N_DEV = 4,
   parameter int N_REG = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_en,
   input  logic [FULL_W-1:0] addr,
   input  logic [HALF_W-1:0] wdata,
   output logic [HALF_W-1:0] rdata
);
   localparam int N_ENT = N_DEV * N_REG;

   if (N_DEV < 1 || N_DEV > 32 || N_REG < 1 || N_REG > 65536 || N_ENT > 4096) begin : g_bad_dim
      $error("register store dimensions out of range");
   end

   logic [DEV_W-1:0]  dev;
   logic [REG_W-1:0]  rnum;
   logic              in_range;
   logic [31:0]       idx;
   logic [HALF_W-1:0] mem_q [N_ENT];

   assign dev      = addr[FULL_W-1:REG_W];
   assign rnum     = addr[REG_W-1:0];
   assign in_range = (32'(dev) < 32'(N_DEV)) && (32'(rnum) < 32'(N_REG));
   assign idx      = 32'(dev) * 32'(N_REG) + 32'(rnum);

   for (genvar g = 0; g < N_ENT; g++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem_q[g] <= '0;
         else if (wr_en && in_range && idx == 32'(g))
            mem_q[g] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      for (int i = 0; i < N_ENT; i++) begin
         if (in_range && idx == 32'(i)) rdata = mem_q[i];
      end
   end
endmodule

// File: rtl/mmd_window_bridge.sv
module mmd_window_bridge
   import mwb_pkg::*;
#(
   parameter int          ADDR_W       = 16,
   parameter int unsigned WORD_SEL_OFF = 32'h3FC,
   parameter int unsigned HALF_SEL_OFF = 32'h9064,
   parameter int unsigned WIN_BASE     = 32'h8000,
   parameter int unsigned WIN_SIZE     = 4096,
   parameter int          N_DEV        = 4,
   parameter int          N_REG        = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [1:0]        layout_mode,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [BUS_W-1:0]  bus_wdata,
   output logic              bus_ack,
   output logic [BUS_W-1:0]  bus_rdata
);
   if (HALF_SEL_OFF >= WIN_BASE && HALF_SEL_OFF < WIN_BASE + WIN_SIZE) begin : g_bad_sel
      $error("halfword select offset must lie outside the data window");
   end
   if (WORD_SEL_OFF >= (1 << ADDR_W) || HALF_SEL_OFF >= (1 << ADDR_W)
       || WIN_BASE + WIN_SIZE > (1 << ADDR_W)) begin : g_bad_range
      $error("offsets do not fit in ADDR_W");
   end

   logic [BUS_W-1:0]  sel_q;
   dec_t              dec_word, dec_half, dec;
   logic              hit_sel, hit_data;
   logic              sel_we, store_we;
   logic [HALF_W-1:0] store_rd;
   logic [BUS_W-1:0]  rdata_d;

   mwb_layout_dec #(
      .ADDR_W(ADDR_W), .HALF(1'b0), .SEL_OFF(WORD_SEL_OFF),
      .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
   ) u_dec_word (
      .addr(bus_addr), .sel_q(sel_q), .dec(dec_word)
   );

   mwb_layout_dec #(
      .ADDR_W(ADDR_W), .HALF(1'b1), .SEL_OFF(HALF_SEL_OFF),
      .WIN_BASE(WIN_BASE), .WIN_SIZE(WIN_SIZE)
   ) u_dec_half (
      .addr(bus_addr), .sel_q(sel_q), .dec(dec_half)
   );

   assign dec      = (layout_mode == MODE_WORD) ? dec_word : dec_half;
   assign hit_sel  = dec.hit_sel;
   assign hit_data = dec.hit_data;
   assign sel_we   = bus_sel && bus_we && hit_sel;
   assign store_we = bus_sel && bus_we && hit_data;

   mwb_select_reg u_sel (
      .clk(clk), .rst_n(rst_n), .wr_en(sel_we), .wdata(bus_wdata), .q(sel_q)
   );

   mwb_mmd_store #(.N_DEV(N_DEV), .N_REG(N_REG)) u_store (
      .clk(clk), .rst_n(rst_n), .wr_en(store_we), .addr(dec.full),
      .wdata(bus_wdata[HALF_W-1:0]), .rdata(store_rd)
   );

   always_comb begin
      rdata_d = '0;
      if (hit_sel)       rdata_d = sel_q;
      else if (hit_data) rdata_d = {{(BUS_W-HALF_W){1'b0}}, store_rd};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bus_ack   <= 1'b0;
         bus_rdata <= '0;
      end else begin
         bus_ack   <= bus_sel;
         bus_rdata <= (bus_sel && !bus_we) ? rdata_d : '0;
      end
   end
endmodule

// File: rtl/mmd_window_bridge_chk.sv
module mmd_window_bridge_chk
   import mwb_pkg::*;
(
   input logic             clk,
   input logic             rst_n,
   input logic             bus_sel,
   input logic             bus_we,
   input logic [BUS_W-1:0] bus_wdata,
   input logic             bus_ack,
   input logic [BUS_W-1:0] bus_rdata,
   input logic             hit_sel,
   input logic             hit_data,
   input logic [BUS_W-1:0] sel_q
);
   assert_ack_follows_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_sel |=> bus_ack);
   assert_no_spurious_ack_R2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_sel |=> !bus_ack);
   assert_sel_written_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && bus_we && hit_sel) |=> sel_q == $past(bus_wdata));
   assert_sel_held_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !(bus_sel && bus_we && hit_sel) |=> $stable(sel_q));
   assert_data_zext_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && hit_data) |=> bus_rdata[31:16] == 16'h0);
   assert_unmapped_zero_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_sel && !bus_we && !hit_sel && !hit_data) |=> bus_rdata == '0);
endmodule

bind mmd_window_bridge mmd_window_bridge_chk u_chk (
   .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
   .bus_wdata(bus_wdata), .bus_ack(bus_ack), .bus_rdata(bus_rdata),
   .hit_sel(hit_sel), .hit_data(hit_data), .sel_q(sel_q)
);

// File: tb/mmd_window_bridge_tb_top.sv
module mmd_window_bridge_tb_top;
   localparam int N_DEV = 4;
   localparam int N_REG = 16;
   localparam logic [15:0] WSEL = 16'h03FC;
   localparam logic [15:0] HSEL = 16'h9064;
   localparam logic [31:0] BASE = 32'h8000;
   localparam logic [31:0] MASK = 32'h0FFF;
   localparam logic [31:0] C45  = 32'h4000_0000;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [1:0]  layout_mode = 2'd0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [15:0] bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic        bus_ack;
   logic [31:0] bus_rdata;

   int checks = 0;
   int failures = 0;
   logic [15:0] model [N_DEV*N_REG];

   always #10 clk = ~clk;

   mmd_window_bridge dut_i (
      .clk(clk), .rst_n(rst_n), .layout_mode(layout_mode), .bus_sel(bus_sel),
      .bus_we(bus_we), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_ack(bus_ack), .bus_rdata(bus_rdata)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic xfer(input logic we, input logic [15:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic ack);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = we; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
      rd = bus_rdata; ack = bus_ack;
   endtask

   task automatic wr(input logic [15:0] a, input logic [31:0] d);
      logic [31:0] rd; logic ack;
      xfer(1'b1, a, d, rd, ack);
   endtask

   task automatic rd(input logic [15:0] a, output logic [31:0] v);
      logic ack;
      xfer(1'b0, a, 32'h0, v, ack);
   endtask

   function automatic logic [31:0] form_addr(input logic [31:0] req, input logic [4:0] dev);
      if ((req & C45) != 0) return req & ~C45;
      return ({27'h0, dev} << 16) | (req & 32'hFFFF);
   endfunction

   function automatic logic [31:0] model_rd(input logic [31:0] full);
      if (full[20:16] < N_DEV && full[15:0] < N_REG)
         return {16'h0, model[full[20:16]*N_REG + full[15:0]]};
      return 32'h0;
   endfunction

   function automatic void model_wr(input logic [31:0] full, input logic [31:0] d);
      if (full[20:16] < N_DEV && full[15:0] < N_REG)
         model[full[20:16]*N_REG + full[15:0]] = d[15:0];
   endfunction

   // word layout host access
   task automatic w_access(input logic we, input logic [31:0] full, input logic [31:0] d,
                           output logic [31:0] v);
      wr(WSEL, full >> 8);
      if (we) begin wr(16'((full & 32'hFF) << 2), d); v = 0; model_wr(full, d); end
      else rd(16'((full & 32'hFF) << 2), v);
   endtask

   // halfword layout host access
   task automatic h_access(input logic we, input logic [31:0] full, input logic [31:0] d,
                           output logic [31:0] v);
      logic [31:0] sh;
      sh = full << 1;
      wr(HSEL, sh & ~MASK);
      if (we) begin wr(16'(BASE + (sh & MASK)), d); v = 0; model_wr(full, d); end
      else rd(16'(BASE + (sh & MASK)), v);
   endtask

   task automatic t_reset();
      logic [31:0] v;
      check("R1 ack after reset", {31'h0, bus_ack}, 32'h0);
      layout_mode = 2'd0; rd(WSEL, v); check("R1 word select reset", v, 32'h0);
      layout_mode = 2'd1; rd(HSEL, v); check("R1 half select reset", v, 32'h0);
   endtask

   task automatic t_ack();
      logic [31:0] v; logic ack;
      layout_mode = 2'd0;
      xfer(1'b0, WSEL, 0, v, ack);
      check("R2 ack one cycle after request", {31'h0, ack}, 32'h1);
      @(negedge clk);
      check("R2 ack drops when idle", {31'h0, bus_ack}, 32'h0);
   endtask

   task automatic t_word();
      logic [31:0] v, f;
      layout_mode = 2'd0;
      wr(WSEL, 32'hDEAD_0100); rd(WSEL, v);
      check("R3 word select readback", v, 32'hDEAD_0100);
      f = form_addr(32'h0000_0005, 5'd1);
      w_access(1'b1, f, 32'hABCD_1234, v);
      w_access(1'b0, f, 0, v);
      check("R4 R11 word data read zero-extended", v, 32'h0000_1234);
      f = form_addr(C45 | 32'h0002_0003, 5'd0);
      w_access(1'b1, f, 32'h0000_5A5A, v);
      w_access(1'b0, f, 0, v);
      check("R4 clause-45 address", v, model_rd(f));
      rd(16'h0014, v);
      check("R4 direct offset reaches dev2 reg3 only via select", v, 32'h0);
   endtask

   task automatic t_priority();
      logic [31:0] v;
      layout_mode = 2'd0;
      wr(WSEL, 32'h0);
      wr(WSEL, 32'h0000_0055); rd(WSEL, v);
      check("R5 offset 0x3FC is the select register", v, 32'h0000_0055);
   endtask

   task automatic t_half();
      logic [31:0] v, f;
      layout_mode = 2'd1;
      wr(HSEL, 32'h1234_5678); rd(HSEL, v);
      check("R6 half select readback", v, 32'h1234_5678);
      f = form_addr(32'h0000_000F, 5'd3);
      h_access(1'b1, f, 32'hFFFF_BEEF, v);
      h_access(1'b0, f, 0, v);
      check("R7 R11 half data read", v, 32'h0000_BEEF);
   endtask

   task automatic t_alias();
      logic [31:0] v, f;
      f = form_addr(32'h0000_0007, 5'd2);
      layout_mode = 2'd2;
      h_access(1'b1, f, 32'h0000_0C0C, v);
      layout_mode = 2'd3;
      h_access(1'b0, f, 0, v);
      check("R8 modes 2 and 3 use half layout", v, 32'h0000_0C0C);
      rd(WSEL, v);
      check("R8 R9 word select offset unmapped in mode 3", v, 32'h0);
   endtask

   task automatic t_unmapped();
      logic [31:0] v, f;
      layout_mode = 2'd0;
      wr(WSEL, 32'h0000_0100);
      wr(HSEL, 32'hFFFF_FFFF);
      rd(WSEL, v); check("R9 half select write ignored in word mode", v, 32'h0000_0100);
      rd(HSEL, v); check("R9 half select reads zero in word mode", v, 32'h0);
      wr(16'h0015, 32'h0000_7777);
      rd(16'h0014, v); check("R9 misaligned word write ignored", v, model_rd(32'h1_0005));
      rd(16'h7000, v); check("R9 unmapped read zero", v, 32'h0);
      layout_mode = 2'd1;
      f = 32'h1_0005;
      wr(HSEL, (f << 1) & ~MASK);
      wr(16'(BASE + ((f << 1) & MASK) + 1), 32'h0000_9999);
      rd(16'(BASE + ((f << 1) & MASK)), v);
      check("R9 odd half offset write ignored", v, model_rd(f));
   endtask

   task automatic t_range();
      logic [31:0] v;
      layout_mode = 2'd0;
      w_access(1'b1, 32'h4_0000, 32'h0000_1111, v);
      w_access(1'b0, 32'h4_0000, 0, v);
      check("R10 device out of range reads zero", v, 32'h0);
      w_access(1'b1, 32'h0_0010, 32'h0000_2222, v);
      w_access(1'b0, 32'h0_0010, 0, v);
      check("R10 register out of range reads zero", v, 32'h0);
      w_access(1'b0, 32'h0_0000, 0, v);
      check("R10 in-range register untouched", v, model_rd(32'h0));
   endtask

   task automatic t_cross();
      logic [31:0] v, f;
      f = 32'h2_000A;
      layout_mode = 2'd1; h_access(1'b1, f, 32'h0000_A1B2, v);
      layout_mode = 2'd0; w_access(1'b0, f, 0, v);
      check("R12 half write word read", v, 32'h0000_A1B2);
      f = 32'h3_0001;
      w_access(1'b1, f, 32'h0000_3C4D, v);
      layout_mode = 2'd1; h_access(1'b0, f, 0, v);
      check("R12 word write half read", v, 32'h0000_3C4D);
   endtask

   initial begin
      for (int i = 0; i < N_DEV*N_REG; i++) model[i] = 16'h0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_ack();
      t_word();
      t_priority();
      t_half();
      t_alias();
      t_unmapped();
      t_range();
      t_cross();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      checks++; failures++;
      $display("FAIL watchdog actual=%0d expected=0", 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end
endmodule